// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This block handles compare-then-branch control flow for a 32-bit processor that fetches 16-bit instruction words. A compare strobe copies two register operands, without modification, into a pair of holding registers. No flag bits are derived at that point. A later branch instruction names one of ten relations, covering equality and signed and unsigned ordering. The unit evaluates that relation on the held pair and produces the next program counter.

The branch outputs are combinational in the current PC, the instruction word and the held operands. The only state is the pair of holding registers. A taken branch lands at the following instruction address plus a sign-extended halfword displacement. A branch that is not taken falls through to the following instruction. A branch that names an undefined condition raises an illegal-instruction flag and leaves the PC on the faulting instruction. Register file access, instruction fetch and exception entry belong to neighbouring blocks.

Top module: `cmp_branch_unit`

## Requirements
- R1: When `cmp_valid` is 1 at a rising clock edge, the holding registers take `cmp_lhs` and `cmp_rhs` unchanged. When it is 0, they keep their value.
- R2: An instruction word is a branch only if bits 15 and 14 are both 1. For any other word, `next_pc` is `pc + 2`, and `br_taken` and `br_illegal` are both 0.
- R3: Bits 13:10 of a branch select the relation, evaluated as held-lhs relation held-rhs. The codes are: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal. `br_taken` is 1 exactly when the selected relation holds.
- R4: A taken branch sets `next_pc` to `pc + 2 + 2*sext(bits 9:0)`. The displacement range is -1024 to +1022 bytes.
- R5: A branch with a defined condition that does not hold sets `next_pc` to `pc + 2`.
- R6: A branch with condition code 10 to 15 sets `br_illegal` to 1 and `br_taken` to 0, and sets `next_pc` equal to `pc`.
- R7: When a compare and a branch arrive in the same cycle, the branch is evaluated on the values held before that compare.
- R8: Synchronous active-low reset clears both holding registers to zero. After reset, an equal-condition branch is therefore taken.
- R9: All PC arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc | input | 32 | Address of the current instruction |
| insn | input | 16 | Current instruction word |
| cmp_valid | input | 1 | Compare strobe; captures the operands |
| cmp_lhs | input | 32 | Left compare operand |
| cmp_rhs | input | 32 | Right compare operand |
| next_pc | output | 32 | Address of the next instruction |
| br_taken | output | 1 | Branch condition held, so the branch is taken |
| br_illegal | output | 1 | Branch named an undefined condition |

## Verification
The assertions assume that `pc`, `insn` and the compare inputs are stable around each rising edge. They also assume that every input is a known value whenever reset is released. The clocked checks look only at cycles after reset has been seen. The bench changes inputs only on falling edges and samples one time unit later, so every check sees settled combinational outputs. The operand sets are built so that signed and unsigned ordering disagree, for example 0x80000000 against 1. In that case the signed-versus-unsigned agreement assertion is vacuous, and it is exercised separately with a pair whose sign bits match.

// File: rtl/cbu_pkg.sv
// Package: shared widths, instruction field positions and condition encodings
// for the compare and conditional branch unit.
// Assumes a 16-bit instruction word whose two top bits mark a branch.
package cbu_pkg;
    localparam int CBU_XLEN     = 32;
    localparam int CBU_ILEN     = 16;
    localparam int CBU_DISP_W   = 10;
    localparam int CBU_COND_W   = 4;
    localparam int CBU_NUM_COND = 10;

    // Relation selector values; the encoding is decoded from the instruction.
    typedef enum logic [CBU_COND_W-1:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_LT  = 4'd2,
        REL_GT  = 4'd3,
        REL_LTU = 4'd4,
        REL_GTU = 4'd5,
        REL_GE  = 4'd6,
        REL_LE  = 4'd7,
        REL_GEU = 4'd8,
        REL_LEU = 4'd9
    } rel_e;
endpackage

// File: rtl/cbu_hold_regs.sv
// Module: holds the two compared operands until the next compare.
// Assumes cmp_valid and the operands are stable around the clock edge.
module cbu_hold_regs #(
    parameter int XLEN = cbu_pkg::CBU_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_valid,
    input  logic [XLEN-1:0] cmp_lhs,
    input  logic [XLEN-1:0] cmp_rhs,
    output logic [XLEN-1:0] lhs_q,
    output logic [XLEN-1:0] rhs_q
);
    // Capture both operands on a compare strobe, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lhs_q <= '0;
            rhs_q <= '0;
        end else if (cmp_valid) begin
            lhs_q <= cmp_lhs;
            rhs_q <= cmp_rhs;
        end
    end

    AST_CAPTURE_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (lhs_q == $past(cmp_lhs) && rhs_q == $past(cmp_rhs))); // R1
    AST_HOLD_WITHOUT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> ($stable(lhs_q) && $stable(rhs_q))); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lhs_q == '0 && rhs_q == '0)); // R8
endmodule

// File: rtl/cbu_relation.sv
// Module: evaluates the selected relation on the held operand pair.
// Assumes the code comes from instruction bits 13:10. Codes at or above
// NUM_COND are reported as undefined.
module cbu_relation #(
    parameter int XLEN     = cbu_pkg::CBU_XLEN,
    parameter int COND_W   = cbu_pkg::CBU_COND_W,
    parameter int NUM_COND = cbu_pkg::CBU_NUM_COND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   lhs,
    input  logic [XLEN-1:0]   rhs,
    input  logic [COND_W-1:0] code,
    output logic              hit,
    output logic              defined
);
    import cbu_pkg::*;

    logic same, below_u, below_s;

    // Base comparisons shared by all ten relations.
    always_comb begin
        same    = (lhs == rhs);
        below_u = (lhs < rhs);
        below_s = ($signed(lhs) < $signed(rhs));
    end

    // Select the relation named by the code.
    always_comb begin
        defined = (int'(code) < NUM_COND);
        case (rel_e'(code))
            REL_EQ:  hit = same;
            REL_NE:  hit = !same;
            REL_LT:  hit = below_s;
            REL_GT:  hit = !below_s && !same;
            REL_LTU: hit = below_u;
            REL_GTU: hit = !below_u && !same;
            REL_GE:  hit = !below_s;
            REL_LE:  hit = below_s || same;
            REL_GEU: hit = !below_u;
            REL_LEU: hit = below_u || same;
            default: hit = 1'b0;
        endcase
    end

    AST_SIGNS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lhs[XLEN-1] == rhs[XLEN-1]) |-> (below_s == below_u)); // R3
    AST_UNDEF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !defined |-> !hit); // R6
endmodule

// File: rtl/cbu_target.sv
// Module: computes the fall-through address and the branch destination.
// Assumes a halfword-scaled, sign-extended displacement relative to pc + 2.
module cbu_target #(
    parameter int XLEN   = cbu_pkg::CBU_XLEN,
    parameter int DISP_W = cbu_pkg::CBU_DISP_W
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   fall_pc,
    output logic [XLEN-1:0]   dest_pc
);
    localparam int EXT_W = XLEN - DISP_W - 1;

    logic [XLEN-1:0] offset;

    // Sign-extend and scale the displacement, then add it to the next address.
    always_comb begin
        offset  = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        fall_pc = pc + XLEN'(2);
        dest_pc = fall_pc + offset;
    end
endmodule

// File: rtl/cmp_branch_unit.sv
// Module: top of the compare and conditional branch unit. It decodes the
// branch form, evaluates the held relation and selects the next PC.
// Assumes that non-branch words are handled elsewhere and fall through here.
module cmp_branch_unit #(
    parameter int XLEN   = cbu_pkg::CBU_XLEN,
    parameter int ILEN   = cbu_pkg::CBU_ILEN,
    parameter int DISP_W = cbu_pkg::CBU_DISP_W,
    parameter int COND_W = cbu_pkg::CBU_COND_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc,
    input  logic [ILEN-1:0] insn,
    input  logic            cmp_valid,
    input  logic [XLEN-1:0] cmp_lhs,
    input  logic [XLEN-1:0] cmp_rhs,
    output logic [XLEN-1:0] next_pc,
    output logic            br_taken,
    output logic            br_illegal
);
    localparam int COND_LO = DISP_W;
    localparam int COND_HI = DISP_W + COND_W - 1;

    logic [XLEN-1:0]   lhs_q, rhs_q, fall_pc, dest_pc;
    logic [COND_W-1:0] code;
    logic [DISP_W-1:0] disp;
    logic              is_branch, hit, defined;

    // Split the instruction word into its branch fields.
    always_comb begin
        is_branch = (insn[ILEN-1:ILEN-2] == 2'b11);
        code      = insn[COND_HI:COND_LO];
        disp      = insn[DISP_W-1:0];
    end

    cbu_hold_regs #(.XLEN(XLEN)) i_hold (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
        .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .lhs_q(lhs_q), .rhs_q(rhs_q)
    );

    cbu_relation #(.XLEN(XLEN), .COND_W(COND_W)) i_rel (
        .clk(clk), .rst_n(rst_n), .lhs(lhs_q), .rhs(rhs_q),
        .code(code), .hit(hit), .defined(defined)
    );

    cbu_target #(.XLEN(XLEN), .DISP_W(DISP_W)) i_tgt (
        .pc(pc), .disp(disp), .fall_pc(fall_pc), .dest_pc(dest_pc)
    );

    // Choose the outcome: fault, taken or fall-through.
    always_comb begin
        br_illegal = is_branch && !defined;
        br_taken   = is_branch && defined && hit;
        if (br_illegal)    next_pc = pc;
        else if (br_taken) next_pc = dest_pc;
        else               next_pc = fall_pc;
    end

    AST_NON_BRANCH_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[ILEN-1:ILEN-2] != 2'b11) |-> (!br_taken && !br_illegal && next_pc == pc + XLEN'(2))); // R2
    AST_FAULT_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> (next_pc == pc && !br_taken)); // R6
    AST_NOT_TAKEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_taken && !br_illegal) |-> (next_pc == pc + XLEN'(2))); // R5
endmodule

// File: tb/test_cmp_branch_unit.sv
module test_cmp_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic [15:0] insn = '0;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_lhs = '0, cmp_rhs = '0;
    logic [31:0] next_pc;
    logic        br_taken, br_illegal;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cmp_branch_unit i_cmp_branch_unit (
        .clk(clk), .rst_n(rst_n), .pc(pc), .insn(insn),
        .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .next_pc(next_pc), .br_taken(br_taken), .br_illegal(br_illegal)
    );

    // Per operand pair: lhs, rhs, and a mask whose bit i is the outcome of code i.
    localparam logic [73:0] VEC [0:2] = '{
        {32'h8000_0000, 32'h0000_0001, 10'd422},
        {32'h0000_0005, 32'h0000_0005, 10'd961},
        {32'h0000_0001, 32'h8000_0000, 10'd602}
    };

    function automatic logic [31:0] disp_bytes(input logic [9:0] d);
        return d[9] ? ((32'(d) - 32'd1024) * 32'd2) : (32'(d) * 32'd2);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_pair(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_lhs = l; cmp_rhs = r;
        insn = 16'h0000;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic branch(input logic [31:0] p, input logic [3:0] c, input logic [9:0] d);
        pc = p; insn = {2'b11, c, d};
        #1;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: after reset, the pair is zero, so equal is taken.
        branch(32'h0000_1000, 4'd0, 10'd4);
        check("R8 reset eq taken", 32'(br_taken), 32'd1);
        check("R8 reset eq target", next_pc, 32'h0000_100A);
        branch(32'h0000_1000, 4'd1, 10'd4);
        check("R8 reset ne not taken", 32'(br_taken), 32'd0);

        // R3/R4/R5: all ten codes on pairs where signed and unsigned order differ.
        for (int p = 0; p < 3; p++) begin
            load_pair(VEC[p][73:42], VEC[p][41:10]);
            for (int c = 0; c < 10; c++) begin
                logic [9:0]  d;
                logic        exp_t;
                logic [31:0] base, exp_pc;
                d      = 10'(c * 91 + p * 137 + 512);
                base   = 32'h0004_0000 + 32'(c * 64);
                exp_t  = VEC[p][c];
                exp_pc = exp_t ? (base + 32'd2 + disp_bytes(d)) : (base + 32'd2);
                branch(base, 4'(c), d);
                check($sformatf("R3 pair%0d code%0d taken", p, c), 32'(br_taken), 32'(exp_t));
                check($sformatf("R4 R5 pair%0d code%0d next_pc", p, c), next_pc, exp_pc);
                check("R6 defined code not illegal", 32'(br_illegal), 32'd0);
            end
        end

        // R3: matching sign bits, signed and unsigned less agree.
        load_pair(32'hFFFF_FFF0, 32'hFFFF_FFFF);
        branch(32'h100, 4'd2, 10'd8);
        check("R3 neg lt signed", 32'(br_taken), 32'd1);
        branch(32'h100, 4'd4, 10'd8);
        check("R3 neg lt unsigned", 32'(br_taken), 32'd1);

        // R6: undefined codes fault and keep the PC.
        for (int c = 10; c < 16; c++) begin
            branch(32'h0000_2222, 4'(c), 10'h155);
            check($sformatf("R6 code%0d illegal", c), 32'(br_illegal), 32'd1);
            check($sformatf("R6 code%0d not taken", c), 32'(br_taken), 32'd0);
            check($sformatf("R6 code%0d pc kept", c), next_pc, 32'h0000_2222);
        end

        // R2: words without both top bits set fall through.
        pc = 32'h0000_3000; insn = 16'h8000; #1;
        check("R2 form 10 falls", next_pc, 32'h0000_3002);
        check("R2 form 10 no flags", 32'({br_taken, br_illegal}), 32'd0);
        insn = 16'h4000; #1;
        check("R2 form 01 falls", next_pc, 32'h0000_3002);
        check("R2 form 01 no flags", 32'({br_taken, br_illegal}), 32'd0);

        // R4: displacement extremes on an equal pair.
        load_pair(32'd9, 32'd9);
        branch(32'h0000_5000, 4'd0, 10'h200);
        check("R4 most negative", next_pc, 32'h0000_5000 + 32'd2 - 32'd1024);
        branch(32'h0000_5000, 4'd0, 10'h1FF);
        check("R4 most positive", next_pc, 32'h0000_5000 + 32'd2 + 32'd1022);
        branch(32'h0000_5000, 4'd0, 10'h3FF);
        check("R4 minus one halfword", next_pc, 32'h0000_5000);

        // R9: wrap at both ends of the address space.
        branch(32'hFFFF_FFFE, 4'd0, 10'd0);
        check("R9 wrap up", next_pc, 32'h0000_0000);
        branch(32'h0000_0000, 4'd0, 10'h200);
        check("R9 wrap down", next_pc, 32'hFFFF_FC02);

        // R7: compare and branch in one cycle use the old pair.
        @(negedge clk);
        cmp_valid = 1'b1; cmp_lhs = 32'd1; cmp_rhs = 32'd2;
        branch(32'h0000_6000, 4'd0, 10'd2);
        check("R7 old pair used", 32'(br_taken), 32'd1);
        @(negedge clk);
        cmp_valid = 1'b0;
        branch(32'h0000_6000, 4'd0, 10'd2);
        check("R7 new pair after edge", 32'(br_taken), 32'd0);

        // R1: a cycle without the strobe leaves the pair untouched.
        cmp_lhs = 32'd7; cmp_rhs = 32'd7;
        @(negedge clk);
        branch(32'h0000_6000, 4'd4, 10'd2);
        check("R1 pair kept without strobe", 32'(br_taken), 32'd1);

        // R8: a reset in mid-run clears a loaded pair.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        branch(32'h0000_7000, 4'd0, 10'd0);
        check("R8 mid-run reset eq taken", 32'(br_taken), 32'd1);

        finish_run();
    end
endmodule